// File: doc/BRIEF.md
# Two-Word-Burst Split-Port SRAM

This block is a synchronous memory with an independent write data bus and read data bus and a single address bus that the two ports share in time. Each access moves two words. A request is sampled on the rising edge of the input clock `k_clk`. A read uses the address present on that rising edge. A write takes its first data word on that same rising edge and takes its address and second word on the following falling edge, which stands in for the rise of the complementary clock. Per-lane byte enables go with each write word.

The read burst comes back on `dout`. The first word is shown during the high phase of the next clock cycle and the second word during the low phase that follows. A valid flag and a word index mark each word. A free-running echo clock runs in step with the output words, so a receiver can capture them. A read that hits the address of the write issued in the previous cycle gets the new bytes forwarded to it. The array itself is updated one cycle after the write request. The array is small and its depth is a parameter.

Top module: `qdr2_burst_sram`

## Requirements
- R1: When `rd_sel_n` is low at a rising edge of `k_clk` (cycle n), the two stored words at `addr` appear on `dout`. Word 0 shows from the rising edge of cycle n+1 until its falling edge. Word 1 shows from that falling edge until the rising edge of cycle n+2. `dout_valid` is high for both words.
- R2: When `wr_sel_n` is low at a rising edge, the data sampled on `din` at that rising edge is stored as word 0. The address sampled on `addr` at the next falling edge and the data sampled on `din` at that falling edge are stored as word 1 of the same burst.
- R3: `bw_n` is active low, and bit i covers lane i, which is `din[9*i+8 : 9*i]`. `bw_n` is sampled together with each write word. A lane whose bit is high keeps its stored value.
- R4: A read issued in the cycle after a write to the same address returns the newly written lanes merged with the older stored lanes.
- R5: When a read and a write to the same address are issued in the same cycle, the read returns the contents from before that write.
- R6: When both selects are high at a rising edge, nothing starts. The memory is unchanged, and no valid output follows from that cycle.
- R7: Whenever `dout_valid` is low, `dout` is all zeros.
- R8: `echo_clk` is high from each rising edge of `k_clk` to the next falling edge and low from each falling edge to the next rising edge. `echo_clk_n` is its complement.
- R9: While `rst_n` is low at the clock edges, `dout` is zero, `dout_valid` is low and `echo_clk` is low. The memory contents are cleared to zero.
- R10: A read issued in every cycle produces an unbroken stream of valid words with no gap between bursts.
- R11: `dout_idx` is 0 while word 0 is shown and 1 while word 1 is shown. It is 0 when `dout_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k_clk | input | 1 | Input clock; the rising edge samples requests, the falling edge samples the write address and second word |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read request |
| wr_sel_n | input | 1 | Active-low write request |
| addr | input | ADDR_W | Shared address: read address on the rise, write address on the fall |
| din | input | LANES*LANE_W | Write data, one word per clock edge |
| bw_n | input | LANES | Active-low lane write enables, one per write word |
| dout | output | LANES*LANE_W | Read data word |
| dout_valid | output | 1 | High while `dout` carries a burst word |
| dout_idx | output | 1 | Position of the shown word within its burst |
| echo_clk | output | 1 | Free-running echo clock aligned to the output words |
| echo_clk_n | output | 1 | Complement of `echo_clk` |

## Verification
A read issued at rising edge n has word 0 due just after rising edge n+1 and word 1 due just after the falling edge that follows. The bench therefore samples 5 ns after each edge and holds the expected values of the last two reads in a two-deep queue. A write issued in cycle n becomes visible to reads issued from cycle n+1 onward. The bench's reference model applies each write only after it has computed the expectation for the read issued in the same cycle. The echo clock is checked at both sample points of every cycle.

// File: rtl/qdr_pkg.sv
// Package: shared types for the two-word-burst split-port SRAM.
// Assumes every burst holds exactly two words.
package qdr_pkg;
    typedef enum logic {
        BEAT_FIRST  = 1'b0,
        BEAT_SECOND = 1'b1
    } beat_e;
endpackage

// File: rtl/qdr_wr_capture.sv
// Write capture: a request on the rising edge takes word 0 and its lane
// enables. The falling edge of the same cycle takes the address, word 1 and
// its lane enables. Assumes the caller commits the burst on the next rising
// edge while wr_act is high.
module qdr_wr_capture #(
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_req,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   din,
    input  logic [LANES-1:0]          bw_n,
    output logic                      wr_act,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [LANES*LANE_W-1:0]   wr_d0,
    output logic [LANES*LANE_W-1:0]   wr_d1,
    output logic [LANES-1:0]          wr_en0,
    output logic [LANES-1:0]          wr_en1
);
    localparam int DW = LANES * LANE_W;

    // Rising edge: register the request, the first word and its enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act <= 1'b0;
            wr_d0  <= '0;
            wr_en0 <= '0;
        end else begin
            wr_act <= wr_req;
            if (wr_req) begin
                wr_d0  <= din;
                wr_en0 <= ~bw_n;
            end
        end
    end

    // Falling edge: register the address and the second word of the burst.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_d1   <= {DW{1'b0}};
            wr_en1  <= '0;
        end else if (wr_act) begin
            wr_addr <= addr;
            wr_d1   <= din;
            wr_en1  <= ~bw_n;
        end
    end
endmodule

// File: rtl/qdr_array.sv
// Storage array: each address holds two words. The pending burst is committed
// on the rising edge with lane masks. A combinational read merges in the
// lanes of the burst committing on that same edge when the addresses match.
// Assumes at most one commit per cycle.
module qdr_array #(
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_act,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES*LANE_W-1:0]   wr_d0,
    input  logic [LANES*LANE_W-1:0]   wr_d1,
    input  logic [LANES-1:0]          wr_en0,
    input  logic [LANES-1:0]          wr_en1,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_w0,
    output logic [LANES*LANE_W-1:0]   rd_w1
);
    localparam int DW    = LANES * LANE_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][1:0][DW-1:0] mem;
    logic                          fwd_hit;

    // Forwarding match against the burst that commits on this edge.
    assign fwd_hit = wr_act && (wr_addr == rd_addr);

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            // Per-lane read mux: forwarded bytes or stored bytes.
            assign rd_w0[g*LANE_W +: LANE_W] = (fwd_hit && wr_en0[g]) ?
                wr_d0[g*LANE_W +: LANE_W] : mem[rd_addr][0][g*LANE_W +: LANE_W];
            assign rd_w1[g*LANE_W +: LANE_W] = (fwd_hit && wr_en1[g]) ?
                wr_d1[g*LANE_W +: LANE_W] : mem[rd_addr][1][g*LANE_W +: LANE_W];

            AST_MASKED_LANE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
                wr_act && !wr_en0[g] |=> mem[$past(wr_addr)][0][g*LANE_W +: LANE_W]
                    == $past(mem[wr_addr][0][g*LANE_W +: LANE_W])); // R3
        end
    endgenerate

    // Commit the pending burst lane by lane; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (wr_act) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr_en0[i]) mem[wr_addr][0][i*LANE_W +: LANE_W] <= wr_d0[i*LANE_W +: LANE_W];
                if (wr_en1[i]) mem[wr_addr][1][i*LANE_W +: LANE_W] <= wr_d1[i*LANE_W +: LANE_W];
            end
        end
    end

    AST_FULL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_act && (&wr_en0) && (&wr_en1) |=>
            mem[$past(wr_addr)][0] == $past(wr_d0) &&
            mem[$past(wr_addr)][1] == $past(wr_d1)); // R2
    AST_IDLE_MEM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_act |=> $stable(mem)); // R6
endmodule

// File: rtl/qdr_echo_gen.sv
// Echo clock generator: a toggle flop on each edge. The XOR of the two flops
// is high after every rising edge and low after every falling edge. Assumes
// reset is held across both edges of at least one cycle.
module qdr_echo_gen (
    input  logic clk,
    input  logic rst_n,
    output logic cq
);
    logic tog_r, tog_f, run;

    // Rising-edge toggle, plus a flag that marks the first cycle out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_r <= 1'b0;
            run   <= 1'b0;
        end else begin
            tog_r <= ~tog_r;
            run   <= 1'b1;
        end
    end

    // Falling-edge toggle.
    always_ff @(negedge clk) begin
        if (!rst_n) tog_f <= 1'b0;
        else        tog_f <= ~tog_f;
    end

    assign cq = tog_r ^ tog_f;

    AST_ECHO_HIGH_PHASE: assert property (@(negedge clk) disable iff (!rst_n)
        run |-> cq); // R8
    AST_ECHO_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !cq); // R8
endmodule

// File: rtl/qdr_rd_pipe.sv
// Read pipeline: captures the merged read words at the request edge, stages
// them for one cycle and shows word 0 in the high phase and word 1 in the low
// phase. Assumes cq is high exactly between a rising edge and the next
// falling edge.
module qdr_rd_pipe
    import qdr_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [DW-1:0] arr_w0,
    input  logic [DW-1:0] arr_w1,
    input  logic          cq,
    output logic [DW-1:0] dout,
    output logic          dout_valid,
    output logic          dout_idx
);
    logic [DW-1:0] buf0, buf1, stg0, stg1, low_w;
    logic          buf_v, stg_v, low_v;
    logic [1:0]    age;
    beat_e         beat;

    // Rising edge: capture the burst, then move it into the output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf0  <= '0;
            buf1  <= '0;
            buf_v <= 1'b0;
            stg0  <= '0;
            stg1  <= '0;
            stg_v <= 1'b0;
        end else begin
            buf_v <= rd_req;
            buf0  <= arr_w0;
            buf1  <= arr_w1;
            stg_v <= buf_v;
            stg0  <= buf_v ? buf0 : '0;
            stg1  <= buf_v ? buf1 : '0;
        end
    end

    // Falling edge: hand the second word to the low-phase register.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            low_w <= '0;
            low_v <= 1'b0;
        end else begin
            low_w <= stg1;
            low_v <= stg_v;
        end
    end

    // Count the cycles since reset so the latency check never looks back past it.
    always_ff @(posedge clk) begin
        if (!rst_n)         age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assign beat       = cq ? BEAT_FIRST : BEAT_SECOND;
    assign dout       = cq ? stg0 : low_w;
    assign dout_valid = cq ? stg_v : low_v;
    assign dout_idx   = dout_valid & (beat == BEAT_SECOND);

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        age >= 2'd2 |-> stg_v == $past(rd_req, 2)); // R1
    AST_IDLE_ZERO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_valid |-> dout == '0); // R7
    AST_IDLE_ZERO_FALL: assert property (@(negedge clk) disable iff (!rst_n)
        !dout_valid |-> dout == '0); // R7
endmodule

// File: rtl/qdr2_burst_sram.sv
// Top: a two-word-burst SRAM with split data buses and a shared address bus.
// Reads sample the address on the rising edge. Writes sample it on the falling
// edge. A write is committed one cycle after its request, and a read in that
// cycle gets the burst forwarded. Assumes an ideal clock with a 50% duty cycle.
module qdr2_burst_sram #(
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int ADDR_W = 4
) (
    input  logic                      k_clk,
    input  logic                      rst_n,
    input  logic                      rd_sel_n,
    input  logic                      wr_sel_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   din,
    input  logic [LANES-1:0]          bw_n,
    output logic [LANES*LANE_W-1:0]   dout,
    output logic                      dout_valid,
    output logic                      dout_idx,
    output logic                      echo_clk,
    output logic                      echo_clk_n
);
    localparam int DW = LANES * LANE_W;

    logic              wr_act;
    logic [ADDR_W-1:0] wr_addr;
    logic [DW-1:0]     wr_d0, wr_d1, rd_w0, rd_w1;
    logic [LANES-1:0]  wr_en0, wr_en1;
    logic              cq;

    qdr_wr_capture #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_wcap (
        .clk(k_clk), .rst_n(rst_n), .wr_req(~wr_sel_n), .addr(addr), .din(din),
        .bw_n(bw_n), .wr_act(wr_act), .wr_addr(wr_addr), .wr_d0(wr_d0),
        .wr_d1(wr_d1), .wr_en0(wr_en0), .wr_en1(wr_en1)
    );

    qdr_array #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_array (
        .clk(k_clk), .rst_n(rst_n), .wr_act(wr_act), .wr_addr(wr_addr),
        .wr_d0(wr_d0), .wr_d1(wr_d1), .wr_en0(wr_en0), .wr_en1(wr_en1),
        .rd_addr(addr), .rd_w0(rd_w0), .rd_w1(rd_w1)
    );

    qdr_echo_gen u_echo (.clk(k_clk), .rst_n(rst_n), .cq(cq));

    qdr_rd_pipe #(.DW(DW)) u_rpipe (
        .clk(k_clk), .rst_n(rst_n), .rd_req(~rd_sel_n), .arr_w0(rd_w0),
        .arr_w1(rd_w1), .cq(cq), .dout(dout), .dout_valid(dout_valid),
        .dout_idx(dout_idx)
    );

    assign echo_clk   = cq;
    assign echo_clk_n = ~cq;
endmodule

// File: tb/qdr2_burst_sram_tb_top.sv
module qdr2_burst_sram_tb_top;
    localparam int LW = 9;
    localparam int LN = 2;
    localparam int AW = 4;
    localparam int DW = LW * LN;
    localparam int DEPTH = 1 << AW;

    logic          k_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_sel_n = 1'b1, wr_sel_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [LN-1:0] bw_n = '1;
    logic [DW-1:0] dout;
    logic          dout_valid, dout_idx, echo_clk, echo_clk_n;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [DW-1:0] model [DEPTH][2];
    // expectation queue: q1 = read from previous cycle, q2 = two cycles back
    bit            q1_v = 0, q2_v = 0;
    logic [DW-1:0] q1_w0, q1_w1, q2_w0, q2_w1;
    string         q1_tag = "R7", q2_tag = "R7";

    qdr2_burst_sram #(.LANE_W(LW), .LANES(LN), .ADDR_W(AW)) dut_i (
        .k_clk(k_clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .addr(addr), .din(din), .bw_n(bw_n), .dout(dout), .dout_valid(dout_valid),
        .dout_idx(dout_idx), .echo_clk(echo_clk), .echo_clk_n(echo_clk_n)
    );

    always #10 k_clk = ~k_clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // lane merge: lane i is written when its active-low enable is 0 (R3)
    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                            logic [LN-1:0] bn);
        logic [DW-1:0] r = old;
        for (int i = 0; i < LN; i++)
            if (!bn[i]) r[i*LW +: LW] = nw[i*LW +: LW];
        return r;
    endfunction

    // One clock cycle: request on the rise, write address/word 1 on the fall.
    task automatic kcycle(string tag, bit rd, bit wr, int raddr, int waddr,
                          logic [DW-1:0] d0, logic [LN-1:0] bn0,
                          logic [DW-1:0] d1, logic [LN-1:0] bn1);
        logic [DW-1:0] e0, e1;
        @(negedge k_clk); #5;
        // word 1 of the read issued two cycles back (R1, R7, R11, R8)
        chk(q2_tag, {31'd0, dout_valid}, {31'd0, q2_v});
        chk(q2_tag, {14'd0, dout}, {14'd0, q2_v ? q2_w1 : {DW{1'b0}}});
        chk("R11", {31'd0, dout_idx}, {31'd0, q2_v});
        chk("R8", {30'd0, echo_clk, echo_clk_n}, 32'd1);
        rd_sel_n = !rd; wr_sel_n = !wr; addr = raddr[AW-1:0]; din = d0; bw_n = bn0;
        e0 = model[raddr][0]; e1 = model[raddr][1];
        @(posedge k_clk); #5;
        // word 0 of the read issued in the previous cycle
        chk(q1_tag, {31'd0, dout_valid}, {31'd0, q1_v});
        chk(q1_tag, {14'd0, dout}, {14'd0, q1_v ? q1_w0 : {DW{1'b0}}});
        chk("R11", {31'd0, dout_idx}, 32'd0);
        chk("R8", {30'd0, echo_clk, echo_clk_n}, 32'd2);
        rd_sel_n = 1'b1; wr_sel_n = 1'b1; addr = waddr[AW-1:0]; din = d1; bw_n = bn1;
        if (wr) begin
            model[waddr][0] = merge(model[waddr][0], d0, bn0);
            model[waddr][1] = merge(model[waddr][1], d1, bn1);
        end
        q2_v = q1_v; q2_w0 = q1_w0; q2_w1 = q1_w1; q2_tag = q1_tag;
        q1_v = rd; q1_w0 = e0; q1_w1 = e1; q1_tag = rd ? tag : "R7";
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) begin model[a][0] = '0; model[a][1] = '0; end
        // reset state (R9)
        repeat (3) @(posedge k_clk);
        #5;
        chk("R9", {31'd0, dout_valid}, 32'd0);
        chk("R9", {14'd0, dout}, 32'd0);
        chk("R9", {31'd0, echo_clk}, 32'd0);
        @(negedge k_clk); #5;
        chk("R9", {31'd0, echo_clk}, 32'd0);
        rst_n = 1'b1;

        // R9: memory cleared; R2 write; R4 forwarded; committed read
        kcycle("R9", 1, 0, 5, 0, '0, '1, '0, '1);
        kcycle("R2", 0, 1, 0, 5, 18'h2A5A5, 2'b00, 18'h15A5A, 2'b00);
        kcycle("R4", 1, 0, 5, 0, '0, '1, '0, '1);
        kcycle("R2", 1, 0, 5, 0, '0, '1, '0, '1);
        // R3: partial lanes, then forwarded and committed reads
        kcycle("R3", 0, 1, 0, 5, 18'h3FFFF, 2'b10, 18'h3FFFF, 2'b01);
        kcycle("R3", 1, 0, 5, 0, '0, '1, '0, '1);
        kcycle("R3", 1, 0, 5, 0, '0, '1, '0, '1);
        // R5: same-cycle read and write to one address, then read again
        kcycle("R5", 1, 1, 7, 7, 18'h11111, 2'b00, 18'h22222, 2'b00);
        kcycle("R4", 1, 0, 7, 0, '0, '1, '0, '1);
        // R6: deselect cycles with busy buses, then memory unchanged
        kcycle("R6", 0, 0, 7, 7, 18'h3FFFF, 2'b00, 18'h3FFFF, 2'b00);
        kcycle("R6", 0, 0, 5, 5, 18'h00000, 2'b00, 18'h00000, 2'b00);
        kcycle("R6", 1, 0, 7, 0, '0, '1, '0, '1);
        // R10: back-to-back reads over different addresses
        for (int a = 0; a < 6; a++) kcycle("R10", 1, 0, a + 4, 0, '0, '1, '0, '1);

        // constrained random traffic on a few addresses to force collisions
        void'($urandom(32'd20240611));
        for (int n = 0; n < 600; n++) begin
            bit rd = ($urandom % 2) == 0;
            bit wr = ($urandom % 2) == 0;
            int ra = $urandom % 4;
            int wa = $urandom % 4;
            kcycle("R1", rd, wr, ra, wa, DW'($urandom), LN'($urandom),
                   DW'($urandom), LN'($urandom));
        end
        // drain the pipeline and check the idle output (R7)
        repeat (3) kcycle("R7", 0, 0, 0, 0, '0, '1, '0, '1);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule